// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the 8-bit status register of a small 8-bit processor core. The ALU reports each operation as a class (add, subtract, logic, rotate through carry), along with its operands, result and carry-chain taps. From these the block updates four arithmetic flags: carry, half-carry, zero and overflow. For subtraction, the carry and half-carry flags carry the "no borrow" meaning, so a set carry after a subtract means that no borrow occurred.

The register also keeps two power-management flags. The power-down flag is set by a halt instruction and cleared by a clear-watchdog instruction. The time-out flag is set when the watchdog expires and cleared by either instruction. Software writes the register through an 8-bit port, but only the four arithmetic flags can be changed that way. The power-management flags can only be read. All flags are registered, so a change becomes visible on the read port one clock after the cause. The overflow flag can be built from the carry taps or from the operand signs, chosen by a parameter.

Top module: `cpu_status_reg`

## Requirements
- R1: While `rst_n` is low and after it is released, every bit of `sr_rd_data` reads 0 until an event changes a flag.
- R2: The bit layout of `sr_rd_data` and `sr_wr_data` is: carry bit 0, half-carry bit 1, zero bit 2, overflow bit 3, power-down bit 4, time-out bit 5. Bits 7 and 6 always read 0.
- R3: For an add (`op_sel`=1), carry is set if the sum exceeds 8 bits. Half-carry is set if the sum of the low nibbles exceeds 4 bits.
- R4: For a subtract (`op_sel`=2), carry is set when A ≥ B unsigned, meaning no borrow. Half-carry is set when A[3:0] ≥ B[3:0].
- R5: For add and subtract, overflow is set when the signed result does not fit in 8 bits, which means the carry into the MSB differs from the carry out of it.
- R6: For add, subtract and logic (`op_sel`=3), zero is set exactly when `alu_res` is 0.
- R7: A logic operation changes only zero. Carry, half-carry and overflow keep their values.
- R8: A rotate through carry (`op_sel`=4) loads carry from `rot_bit` and leaves the other three arithmetic flags unchanged.
- R9: When `op_sel` is 0 or 5 to 7 and no write is made, the arithmetic flags keep their values.
- R10: A write (`sr_wr_en`) loads bits 3..0 from `sr_wr_data[3:0]`. It takes priority over an ALU operation in the same cycle. It never changes bits 4 and 5.
- R11: `halt_exec` sets power-down and clears time-out.
- R12: `wdt_clr_exec` clears both power-down and time-out. If it coincides with `halt_exec`, the halt effect applies.
- R13: `wdt_expire` sets time-out, even when it coincides with a halt or a clear-watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| op_sel | input | 3 | Operation class: 0 none, 1 add, 2 subtract, 3 logic, 4 rotate through carry |
| opnd_a | input | 8 | First ALU operand |
| opnd_b | input | 8 | Second ALU operand (subtrahend for subtract) |
| alu_res | input | 8 | ALU result |
| cy_out | input | 1 | Carry out of MSB (for subtract, 1 = no borrow) |
| cy_msb_in | input | 1 | Carry into the MSB position |
| cy_nib | input | 1 | Carry out of the low nibble (for subtract, 1 = no borrow) |
| rot_bit | input | 1 | Bit rotated into carry |
| halt_exec | input | 1 | Halt instruction strobe |
| wdt_clr_exec | input | 1 | Clear-watchdog instruction strobe |
| wdt_expire | input | 1 | Watchdog time-out strobe |
| sr_wr_en | input | 1 | Software write strobe |
| sr_wr_data | input | 8 | Software write data |
| sr_rd_data | output | 8 | Status register read value |

## Verification
The hardest cases to reach are the ones where the flags are not supposed to move. Showing that logic, rotate and idle cycles leave carry, half-carry and overflow alone needs those flags set to 1 first. The bench therefore runs an overflowing add, or writes all ones, before each such operation. It then compares the untouched bits against the values it predicted.

The coincident strobes are the other hard case, because the ALU never produces them in normal use. These are halt with clear-watchdog, expiry with halt, and a write with an ALU operation. The bench drives each pair in the same cycle and checks which one wins.

// File: rtl/cpu_sr_pkg.sv
package cpu_sr_pkg;

   typedef enum logic [2:0] {
      OPC_NONE  = 3'd0,
      OPC_ADD   = 3'd1,
      OPC_SUB   = 3'd2,
      OPC_LOGIC = 3'd3,
      OPC_ROTC  = 3'd4
   } opc_e;

   localparam int unsigned SR_W    = 8;
   localparam int unsigned ARITH_W = 4;
   localparam int unsigned BIT_C   = 0;
   localparam int unsigned BIT_HC  = 1;
   localparam int unsigned BIT_Z   = 2;
   localparam int unsigned BIT_V   = 3;
   localparam int unsigned BIT_PD  = 4;
   localparam int unsigned BIT_WT  = 5;

   typedef struct packed {
      logic v;
      logic z;
      logic hc;
      logic c;
   } arith_flags_t;

endpackage

// File: rtl/sr_arith_next.sv
module sr_arith_next
   import cpu_sr_pkg::*;
#(
   parameter int unsigned DW     = 8,
   parameter int unsigned OV_SRC = 0
) (
   input  opc_e          opc,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic [DW-1:0] res,
   input  logic          cy_out,
   input  logic          cy_msb_in,
   input  logic          cy_nib,
   input  logic          rot_bit,
   input  arith_flags_t  cur,
   output arith_flags_t  nxt
);

   localparam int unsigned MSB = DW - 1;

   logic ov_w;
   logic res_zero;

   assign res_zero = (res == '0);

   generate
      if (OV_SRC == 0) begin : g_ov_taps
         logic unused_ops;
         assign unused_ops = ^{a, b};
         assign ov_w = cy_msb_in ^ cy_out;
      end else begin : g_ov_signs
         logic b_eff;
         logic unused_tap;
         assign unused_tap = cy_msb_in;
         assign b_eff = (opc == OPC_SUB) ? ~b[MSB] : b[MSB];
         assign ov_w  = (a[MSB] == b_eff) && (res[MSB] != a[MSB]);
      end
   endgenerate

   always_comb begin
      nxt = cur;
      unique case (opc)
         OPC_ADD, OPC_SUB: begin
            nxt.c  = cy_out;
            nxt.hc = cy_nib;
            nxt.z  = res_zero;
            nxt.v  = ov_w;
         end
         OPC_LOGIC: nxt.z = res_zero;
         OPC_ROTC:  nxt.c = rot_bit;
         default:   nxt = cur;
      endcase
   end

endmodule

// File: rtl/sr_power_flags.sv
module sr_power_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic halt_exec,
   input  logic wdt_clr_exec,
   input  logic wdt_expire,
   output logic pd_q,
   output logic wt_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pd_q <= 1'b0;
         wt_q <= 1'b0;
      end else begin
         if (halt_exec)
            pd_q <= 1'b1;
         else if (wdt_clr_exec)
            pd_q <= 1'b0;

         if (wdt_expire)
            wt_q <= 1'b1;
         else if (halt_exec || wdt_clr_exec)
            wt_q <= 1'b0;
      end
   end

endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
   import cpu_sr_pkg::*;
#(
   parameter int unsigned DW     = 8,
   parameter int unsigned OV_SRC = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [2:0]      op_sel,
   input  logic [DW-1:0]   opnd_a,
   input  logic [DW-1:0]   opnd_b,
   input  logic [DW-1:0]   alu_res,
   input  logic            cy_out,
   input  logic            cy_msb_in,
   input  logic            cy_nib,
   input  logic            rot_bit,
   input  logic            halt_exec,
   input  logic            wdt_clr_exec,
   input  logic            wdt_expire,
   input  logic            sr_wr_en,
   input  logic [SR_W-1:0] sr_wr_data,
   output logic [SR_W-1:0] sr_rd_data
);

   generate
      if (DW < 2) begin : g_bad_dw
         $error("cpu_status_reg: DW must be at least 2");
      end
      if (OV_SRC > 1) begin : g_bad_ov
         $error("cpu_status_reg: OV_SRC must be 0 (taps) or 1 (signs)");
      end
   endgenerate

   arith_flags_t ar_q;
   arith_flags_t ar_nxt;
   arith_flags_t wr_flags;
   logic         pd_q;
   logic         wt_q;
   logic [SR_W-ARITH_W-1:0] unused_wr;

   assign wr_flags  = arith_flags_t'(sr_wr_data[ARITH_W-1:0]);
   assign unused_wr = sr_wr_data[SR_W-1:ARITH_W];

   sr_arith_next #(
      .DW     (DW),
      .OV_SRC (OV_SRC)
   ) u_next (
      .opc       (opc_e'(op_sel)),
      .a         (opnd_a),
      .b         (opnd_b),
      .res       (alu_res),
      .cy_out    (cy_out),
      .cy_msb_in (cy_msb_in),
      .cy_nib    (cy_nib),
      .rot_bit   (rot_bit),
      .cur       (ar_q),
      .nxt       (ar_nxt)
   );

   sr_power_flags u_pwr (
      .clk          (clk),
      .rst_n        (rst_n),
      .halt_exec    (halt_exec),
      .wdt_clr_exec (wdt_clr_exec),
      .wdt_expire   (wdt_expire),
      .pd_q         (pd_q),
      .wt_q         (wt_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ar_q <= '0;
      else if (sr_wr_en)
         ar_q <= wr_flags;
      else
         ar_q <= ar_nxt;
   end

   always_comb begin
      sr_rd_data         = '0;
      sr_rd_data[BIT_C]  = ar_q.c;
      sr_rd_data[BIT_HC] = ar_q.hc;
      sr_rd_data[BIT_Z]  = ar_q.z;
      sr_rd_data[BIT_V]  = ar_q.v;
      sr_rd_data[BIT_PD] = pd_q;
      sr_rd_data[BIT_WT] = wt_q;
   end

endmodule

// File: rtl/cpu_status_reg_chk.sv
module cpu_status_reg_chk
   import cpu_sr_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] op_sel,
   input logic       rot_bit,
   input logic       halt_exec,
   input logic       wdt_clr_exec,
   input logic       wdt_expire,
   input logic       sr_wr_en,
   input logic [7:0] sr_wr_data,
   input logic [7:0] sr_rd_data
);

   always @(negedge clk)
      if (rst_n)
         a_r2_upper_zero: assert (sr_rd_data[7:6] == 2'b00);

   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (sr_rd_data == 8'h00));

   a_r7_logic_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 3'd3 && !sr_wr_en) |=>
         ({sr_rd_data[3], sr_rd_data[1:0]} == $past({sr_rd_data[3], sr_rd_data[1:0]})));

   a_r8_rot_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 3'd4 && !sr_wr_en) |=>
         (sr_rd_data[0] == $past(rot_bit)) && (sr_rd_data[3:1] == $past(sr_rd_data[3:1])));

   a_r9_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 3'd0 && !sr_wr_en) |=> $stable(sr_rd_data[3:0]));

   a_r10_write_low: assert property (@(posedge clk) disable iff (!rst_n)
      sr_wr_en |=> (sr_rd_data[3:0] == $past(sr_wr_data[3:0])));

   a_r11_halt: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_exec && !wdt_expire) |=> (sr_rd_data[4] && !sr_rd_data[5]));

   a_r12_clear_wdt: assert property (@(posedge clk) disable iff (!rst_n)
      (wdt_clr_exec && !halt_exec && !wdt_expire) |=> (sr_rd_data[5:4] == 2'b00));

   a_r13_expire: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_expire |=> sr_rd_data[5]);

endmodule

bind cpu_status_reg cpu_status_reg_chk u_chk (.*);

// File: tb/cpu_status_reg_test.sv
module cpu_status_reg_test;

   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    op_sel = '0;
   logic [DW-1:0] opnd_a = '0, opnd_b = '0, alu_res = '0;
   logic          cy_out = 1'b0, cy_msb_in = 1'b0, cy_nib = 1'b0, rot_bit = 1'b0;
   logic          halt_exec = 1'b0, wdt_clr_exec = 1'b0, wdt_expire = 1'b0;
   logic          sr_wr_en = 1'b0;
   logic [7:0]    sr_wr_data = '0;
   logic [7:0]    sr_rd_data;

   int n_chk = 0;
   int n_fail = 0;
   logic [3:0] e_ar = '0;
   logic       e_pd = 1'b0, e_wt = 1'b0;

   always #10 clk = ~clk;

   cpu_status_reg uut (.*);

   task automatic check(input string req, input logic [7:0] exp);
      n_chk++;
      if (sr_rd_data !== exp) begin
         n_fail++;
         $display("FAIL %s: status got %02h expected %02h", req, sr_rd_data, exp);
      end
   endtask

   function automatic logic [7:0] exp_sr();
      return {2'b00, e_wt, e_pd, e_ar};
   endfunction

   // drive one ALU op for a cycle, with taps modelled like a real adder
   task automatic alu_op(input logic [2:0] opc, input logic [7:0] a, input logic [7:0] b,
                         input logic rb);
      logic [8:0] s;
      logic [7:0] nb;
      @(negedge clk);
      op_sel = opc; opnd_a = a; opnd_b = b; rot_bit = rb;
      nb = (opc == 3'd2) ? ~b : b;
      s  = {1'b0, a} + {1'b0, nb} + ((opc == 3'd2) ? 9'd1 : 9'd0);
      cy_nib    = (({1'b0, a[3:0]} + {1'b0, nb[3:0]} + ((opc == 3'd2) ? 5'd1 : 5'd0)) > 5'd15);
      cy_msb_in = (({1'b0, a[6:0]} + {1'b0, nb[6:0]} + ((opc == 3'd2) ? 8'd1 : 8'd0)) > 8'd127);
      cy_out    = s[8];
      alu_res   = (opc == 3'd3) ? (a & b) : s[7:0];
      @(negedge clk);
      op_sel = '0; rot_bit = 1'b0;
   endtask

   // expectations from the requirement text, not from the taps
   task automatic t_add(input logic [7:0] a, input logic [7:0] b);
      int sa, sb, ss;
      logic [7:0] r;
      r = a + b;
      sa = $signed(a); sb = $signed(b); ss = sa + sb;
      alu_op(3'd1, a, b, 1'b0);
      e_ar = {(ss > 127 || ss < -128), (r == 0), (a[3:0] + b[3:0] > 15), (int'(a) + int'(b) > 255)};
      check("R3/R5/R6 add", exp_sr());
   endtask

   task automatic t_sub(input logic [7:0] a, input logic [7:0] b);
      int sa, sb, ss;
      logic [7:0] r;
      r = a - b;
      sa = $signed(a); sb = $signed(b); ss = sa - sb;
      alu_op(3'd2, a, b, 1'b0);
      e_ar = {(ss > 127 || ss < -128), (r == 0), (a[3:0] >= b[3:0]), (a >= b)};
      check("R4/R5/R6 subtract", exp_sr());
   endtask

   task automatic t_write(input logic [7:0] d, input logic [2:0] opc, input string req);
      @(negedge clk);
      sr_wr_en = 1'b1; sr_wr_data = d; op_sel = opc;
      opnd_a = 8'h00; opnd_b = 8'h00; alu_res = 8'h00; cy_out = 1'b0; cy_nib = 1'b0;
      cy_msb_in = 1'b0;
      @(negedge clk);
      sr_wr_en = 1'b0; op_sel = '0;
      e_ar = d[3:0];
      check(req, exp_sr());
   endtask

   task automatic t_pwr(input logic h, input logic c, input logic x, input string req);
      @(negedge clk);
      halt_exec = h; wdt_clr_exec = c; wdt_expire = x;
      @(negedge clk);
      halt_exec = 1'b0; wdt_clr_exec = 1'b0; wdt_expire = 1'b0;
      if (h) e_pd = 1'b1; else if (c) e_pd = 1'b0;
      if (x) e_wt = 1'b1; else if (h || c) e_wt = 1'b0;
      check(req, exp_sr());
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1 reset held", 8'h00);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      e_ar = '0; e_pd = 1'b0; e_wt = 1'b0;
      check("R1 after reset", 8'h00);
   endtask

   task automatic t_logic();
      t_write(8'h0F, 3'd0, "R10 preset");
      alu_op(3'd3, 8'hF0, 8'h0F, 1'b0);
      e_ar = 4'b1111;
      check("R7 logic zero keeps C/HC/V", exp_sr());
      alu_op(3'd3, 8'hF3, 8'h31, 1'b0);
      e_ar = 4'b1011;
      check("R6 R7 logic nonzero", exp_sr());
   endtask

   task automatic t_rot();
      t_write(8'h0E, 3'd0, "R10 preset");
      alu_op(3'd4, 8'h00, 8'h00, 1'b1);
      e_ar = 4'b1111;
      check("R8 rotate loads 1", exp_sr());
      alu_op(3'd4, 8'h55, 8'hAA, 1'b0);
      e_ar = 4'b1110;
      check("R8 rotate loads 0", exp_sr());
   endtask

   task automatic t_idle();
      alu_op(3'd0, 8'h00, 8'h00, 1'b1);
      check("R9 idle op", exp_sr());
      alu_op(3'd7, 8'h00, 8'h00, 1'b1);
      check("R9 reserved op", exp_sr());
   endtask

   initial begin
      t_reset();
      t_add(8'h0F, 8'h01);
      t_add(8'h7F, 8'h01);
      t_add(8'hFF, 8'h01);
      t_add(8'h80, 8'h80);
      t_sub(8'h05, 8'h03);
      t_sub(8'h03, 8'h05);
      t_sub(8'h80, 8'h01);
      t_sub(8'h44, 8'h44);
      t_sub(8'h10, 8'h01);
      t_logic();
      t_rot();
      t_idle();
      t_write(8'hFF, 3'd1, "R10 write beats add, R2 upper zero");
      t_write(8'hC5, 3'd0, "R10 write pattern");
      t_pwr(1'b1, 1'b0, 1'b0, "R11 halt");
      t_write(8'h30, 3'd0, "R10 write leaves power flags");
      t_pwr(1'b0, 1'b0, 1'b1, "R13 expire");
      t_pwr(1'b1, 1'b0, 1'b0, "R11 halt clears time-out");
      t_pwr(1'b0, 1'b1, 1'b0, "R12 clear watchdog");
      t_pwr(1'b1, 1'b1, 1'b0, "R12 halt wins over clear");
      t_pwr(1'b0, 1'b1, 1'b1, "R13 expire beats clear");
      t_pwr(1'b1, 1'b0, 1'b1, "R13 expire with halt");
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      e_ar = '0; e_pd = 1'b0; e_wt = 1'b0;
      check("R1 mid-run reset", exp_sr());
      rst_n = 1'b1;
      @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, got no finish expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule